// File: doc/BRIEF.md
# Guarded Mode Register Controller

This block sits behind a simple single-cycle register bus and owns an operating-mode register that protects itself from stray writes. Software first writes a proposed mode word to a proposal address, then writes the bitwise complement of that word to a separate confirmation address. Only a matching confirmation commits the proposal. A proposal must also carry its own write-enable flag, so a random store that happens to hit the proposal address is thrown away. A mismatching confirmation drops the proposal and latches an error bit that software can read.

The committed mode word drives the block's mode outputs. Its low two bits are the mode code and the upper bits are flags passed through to the rest of the chip. A status register reports power-down readiness, a pending proposal and the sticky error. A pair of identification registers returns a fixed value and its complement. While the committed code is power-down, all writes are ignored. The only way out is a run of consecutive reads of a dedicated dummy location, after which the mode code returns to normal. Accesses to any other address act as no-ops: they change no state.

Top module: `gm_guarded_mode`

## Requirements
- R1: After reset the committed mode is 0x00, no proposal is pending and the error bit is clear, so a status read returns 0x0000.
- R2: A write to the proposal address whose bit 2 (0x04, write enable) is set becomes pending. The committed mode takes the pending value at the clock edge of the next confirmation-address write, and only if that write's data equals the 16-bit bitwise inverse of the zero-extended proposal.
- R3: A proposal write with bit 2 clear is ignored and leaves any earlier pending proposal intact.
- R4: A confirmation write that does not match drops the pending proposal and sets status bit 0 (error). The bit stays set until reset, and the dropped proposal can no longer be committed.
- R5: A confirmation write with nothing pending changes nothing.
- R6: A read returns its data one cycle after the request, with rd_valid_o high in that cycle. The ID address reads 0x0400 and the inverted-ID address reads 0xFBFF.
- R7: Status bit 7 is set when the mode code is normal (1) and nothing is pending. Bit 1 is set while a proposal is pending, and bit 0 is the error bit.
- R8: Mode code values are reset = 0, normal = 1 and power-down = 2, in bits 1:0 of the mode word. Code 2 raises pdown_o, and while it is committed every bus write is ignored.
- R9: In power-down, 12 consecutive reads of the dummy address set the mode code to normal and keep the flag bits. Any other access in between restarts the count; idle bus cycles do not.
- R10: A read of the proposal address returns the committed mode word, zero-extended.
- R11: Accesses to unmapped addresses change no state. The sequence commit reset, no-op, commit normal therefore ends in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Bus access in this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Register address |
| req_wdata_i | input | DATA_W | Write data |
| rd_valid_o | output | 1 | Read data valid (one cycle after a read) |
| rd_data_o | output | DATA_W | Read data |
| mode_o | output | 8 | Committed mode word |
| pdown_o | output | 1 | Committed mode code is power-down |

## Verification
The bench builds the block with its default parameters: a 16-bit data bus, an 8-bit address map and a wake count of 12. With these values a full wake run, an interrupted run and a completed run all fit in a few hundred cycles. The bench also reaches the full 16-bit inverse comparison, including the zero upper byte of the proposal. A behavioural model tracks mode, pending proposal, error and wake count. It is compared with the outputs on every cycle through the initialisation order, rejected proposals, bad and orphan confirmations, blocked writes in power-down and the wake sequence.

// File: rtl/gm_pkg.sv
package gm_pkg;
    localparam int MODE_W = 8;
    localparam int FLAG_WE_BIT = 2;
    localparam logic [1:0] CODE_RESET  = 2'd0;
    localparam logic [1:0] CODE_NORMAL = 2'd1;
    localparam logic [1:0] CODE_PDOWN  = 2'd2;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              pend_v;
        logic [MODE_W-1:0] pend;
        logic              err;
    } commit_st_t;
endpackage

// File: rtl/gm_commit.sv
module gm_commit
    import gm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mode_i,
    input  logic              wr_conf_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wake_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              pend_o,
    output logic              err_o
);
    localparam int PAD_W = DATA_W - MODE_W;

    commit_st_t st_d, st_q;
    logic [DATA_W-1:0] expect_conf;

    always_comb begin
        st_d = st_q;
        expect_conf = ~{{PAD_W{1'b0}}, st_q.pend};
        if (wake_i) begin
            st_d.mode = {st_q.mode[MODE_W-1:2], CODE_NORMAL};
        end else if (wr_mode_i) begin
            if (wdata_i[FLAG_WE_BIT]) begin
                st_d.pend_v = 1'b1;
                st_d.pend   = wdata_i[MODE_W-1:0];
            end
        end else if (wr_conf_i && st_q.pend_v) begin
            st_d.pend_v = 1'b0;
            if (wdata_i == expect_conf) begin
                st_d.mode = st_q.pend;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign pend_o = st_q.pend_v;
    assign err_o  = st_q.err;

    // R2
    mode_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != $past(st_q.mode)) |-> $past((wr_conf_i && st_q.pend_v) || wake_i));

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q.err) |-> st_q.err);

    // R3
    no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode_i && !wdata_i[FLAG_WE_BIT] && !wake_i)
        |=> ($stable(st_q.pend_v) && $stable(st_q.pend) && $stable(st_q.mode)));
endmodule

// File: rtl/gm_wake.sv
module gm_wake #(
    parameter int N = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic acc_i,
    input  logic dummy_i,
    output logic wake_o
);
    localparam int CNT_W = $clog2(N + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        wake_o = 1'b0;
        if (!active_i) begin
            cnt_d = '0;
        end else if (acc_i) begin
            if (dummy_i) begin
                if (cnt_q == LAST) begin
                    cnt_d  = '0;
                    wake_o = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end else begin
                cnt_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(N));

    // R9
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && acc_i && !dummy_i) |=> (cnt_q == '0));
endmodule

// File: rtl/gm_guarded_mode.sv
module gm_guarded_mode
    import gm_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter int              DATA_W     = 16,
    parameter int              WAKE_READS = 12,
    parameter logic [ADDR_W-1:0] A_MODE   = 8'h10,
    parameter logic [ADDR_W-1:0] A_CONF   = 8'h12,
    parameter logic [ADDR_W-1:0] A_STAT   = 8'h14,
    parameter logic [ADDR_W-1:0] A_ID     = 8'h20,
    parameter logic [ADDR_W-1:0] A_IDINV  = 8'h22,
    parameter logic [ADDR_W-1:0] A_DUMMY  = 8'hFE,
    parameter logic [DATA_W-1:0] ID_VAL   = 16'h0400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              pdown_o
);
    localparam int PD_READY_BIT = 7;
    localparam int PEND_BIT     = 1;
    localparam int ERR_BIT      = 0;

    typedef struct packed {
        logic              v;
        logic [DATA_W-1:0] d;
    } rd_st_t;

    rd_st_t rd_d, rd_q;

    logic wr, rd, wr_mode, wr_conf, dummy_rd, wake;
    logic pend, err;
    logic [MODE_W-1:0] mode;
    logic [DATA_W-1:0] stat;

    assign wr       = req_valid_i && req_write_i;
    assign rd       = req_valid_i && !req_write_i;
    assign pdown_o  = (mode[1:0] == CODE_PDOWN);
    assign wr_mode  = wr && !pdown_o && (req_addr_i == A_MODE);
    assign wr_conf  = wr && !pdown_o && (req_addr_i == A_CONF);
    assign dummy_rd = rd && (req_addr_i == A_DUMMY);

    gm_commit #(.DATA_W(DATA_W)) u_commit (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mode_i (wr_mode),
        .wr_conf_i (wr_conf),
        .wdata_i   (req_wdata_i),
        .wake_i    (wake),
        .mode_o    (mode),
        .pend_o    (pend),
        .err_o     (err)
    );

    gm_wake #(.N(WAKE_READS)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (pdown_o),
        .acc_i    (req_valid_i),
        .dummy_i  (dummy_rd),
        .wake_o   (wake)
    );

    always_comb begin
        stat               = '0;
        stat[PD_READY_BIT] = (mode[1:0] == CODE_NORMAL) && !pend;
        stat[PEND_BIT]     = pend;
        stat[ERR_BIT]      = err;

        rd_d.v = rd;
        rd_d.d = '0;
        if (rd) begin
            if (req_addr_i == A_MODE) begin
                rd_d.d = DATA_W'(mode);
            end else if (req_addr_i == A_STAT) begin
                rd_d.d = stat;
            end else if (req_addr_i == A_ID) begin
                rd_d.d = ID_VAL;
            end else if (req_addr_i == A_IDINV) begin
                rd_d.d = ~ID_VAL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid_o = rd_q.v;
    assign rd_data_o  = rd_q.d;
    assign mode_o     = mode;

    // R6
    rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(req_valid_i && !req_write_i));

    // R8
    pd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pdown_o && req_valid_i && req_write_i) |=> $stable(mode_o));
endmodule

// File: tb/tb_gm_guarded_mode.sv
module tb_gm_guarded_mode;
    localparam int A_MODE = 8'h10, A_CONF = 8'h12, A_STAT = 8'h14;
    localparam int A_ID = 8'h20, A_IDINV = 8'h22, A_DUMMY = 8'hFE, A_NOP = 8'h3E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rd_valid_o, pdown_o;
    logic [15:0] rd_data_o;
    logic [7:0]  mode_o;

    int    n_chk = 0, n_bad = 0;
    string cur_req = "R1";
    bit    done = 0;

    // model state
    int m_mode = 0, m_pv = 0, m_pend = 0, m_err = 0, m_cnt = 0;
    int m_rdv = 0, m_rdd = 0;

    always #2 clk = ~clk;

    gm_guarded_mode dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
        .mode_o(mode_o), .pdown_o(pdown_o)
    );

    always @(posedge clk) begin
        int pd, a, d;
        if (!rst_n) begin
            m_mode = 0; m_pv = 0; m_pend = 0; m_err = 0; m_cnt = 0; m_rdv = 0; m_rdd = 0;
        end else begin
            a  = int'(req_addr);
            d  = int'(req_wdata);
            pd = ((m_mode % 4) == 2);
            m_rdv = (req_valid && !req_write) ? 1 : 0;
            m_rdd = 0;
            if (m_rdv == 1) begin
                case (a)
                    A_MODE:  m_rdd = m_mode;
                    A_STAT:  m_rdd = (((m_mode % 4) == 1 && m_pv == 0) ? 128 : 0) + 2 * m_pv + m_err;
                    A_ID:    m_rdd = 16'h0400;
                    A_IDINV: m_rdd = 16'hFBFF;
                    default: m_rdd = 0;
                endcase
            end
            if (!pd) m_cnt = 0;
            if (req_valid) begin
                if (pd) begin
                    if (!req_write && a == A_DUMMY) begin
                        m_cnt = m_cnt + 1;
                        if (m_cnt == 12) begin
                            m_cnt = 0;
                            m_mode = (m_mode / 4) * 4 + 1;
                        end
                    end else begin
                        m_cnt = 0;
                    end
                end else if (req_write) begin
                    if (a == A_MODE) begin
                        if ((d / 4) % 2 == 1) begin m_pv = 1; m_pend = d % 256; end
                    end else if (a == A_CONF && m_pv == 1) begin
                        m_pv = 0;
                        if (d == 65535 - m_pend) m_mode = m_pend;
                        else m_err = 1;
                    end
                end
            end
        end
    end

    task automatic check(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check("mode_o", int'(mode_o), m_mode);
            check("pdown_o", int'(pdown_o), ((m_mode % 4) == 2) ? 1 : 0);
            check("rd_valid_o", int'(rd_valid_o), m_rdv);
            if (m_rdv == 1) check("rd_data_o", int'(rd_data_o), m_rdd);
        end
    end

    task automatic acc(input logic w, input int a, input int d);
        @(negedge clk); #1;
        req_valid = 1'b1; req_write = w; req_addr = 8'(a); req_wdata = 16'(d);
        @(negedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic wr(input int a, input int d); acc(1'b1, a, d); endtask
    task automatic rd(input int a); acc(1'b0, a, 0); endtask

    task automatic summary;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired in %s", cur_req);
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state, R6 id reads, R10 mode read
        cur_req = "R1";  rd(A_STAT); rd(A_MODE);
        cur_req = "R6";  rd(A_ID); rd(A_IDINV);
        // R11 init order: reset commit, no-op, normal commit
        cur_req = "R2";  wr(A_MODE, 16'h0004); wr(A_CONF, 16'hFFFB);
        cur_req = "R11"; rd(A_NOP); wr(A_NOP, 16'h1234); rd(A_MODE);
        cur_req = "R2";  wr(A_MODE, 16'h0005); rd(A_NOP); wr(A_CONF, 16'hFFFA);
        cur_req = "R7";  rd(A_STAT);
        cur_req = "R10"; rd(A_MODE);
        // R3 proposal without enable flag
        cur_req = "R3";  wr(A_MODE, 16'h0001); rd(A_STAT);
        wr(A_MODE, 16'h0025); rd(A_STAT); wr(A_MODE, 16'h0002); wr(A_CONF, 16'hFFDA); rd(A_MODE);
        // R5 orphan confirm
        cur_req = "R5";  wr(A_CONF, 16'h1234); rd(A_STAT); rd(A_MODE);
        // R4 mismatching confirm, then late correct confirm
        cur_req = "R4";  wr(A_MODE, 16'h0006); wr(A_CONF, 16'h00F9); rd(A_STAT);
        wr(A_CONF, 16'hFFF9); rd(A_MODE); rd(A_STAT);
        // R8 power-down blocks writes
        cur_req = "R8";  wr(A_MODE, 16'h0006); wr(A_CONF, 16'hFFF9); rd(A_STAT);
        wr(A_MODE, 16'h0005); wr(A_CONF, 16'hFFFA); rd(A_MODE);
        // R9 wake sequence with interruption
        cur_req = "R9";
        for (int i = 0; i < 5; i++) rd(A_DUMMY);
        rd(A_STAT);
        for (int i = 0; i < 11; i++) rd(A_DUMMY);
        rd(A_MODE);
        for (int i = 0; i < 12; i++) rd(A_DUMMY);
        rd(A_MODE); rd(A_STAT);
        repeat (3) @(negedge clk);
        summary();
    end
endmodule